// File: doc/BRIEF.md
# Multi-Mode Microcontroller I/O Port

This block is one 8-bit bidirectional port of a microcontroller peripheral chip. Each pin can act as plain I/O under software control. It can also carry a combinational output supplied by neighbouring logic, or take in high address bits that are captured while the address-latch strobe is high. The pad is modelled as three separate signals per pin: a value to drive, an output enable, and the sampled input. A per-pin drive option is also passed to the pad.

Software reaches the port through a small byte-wide register interface. The registers are the live pin inputs, the output byte, a direction mask, a drive-option byte and a mode byte. A pin drives whenever its direction bit or its externally supplied enable term is set. The upper four pins can be switched to open-drain operation, and the lower four pins can request fast edges. Register access and the strobe are plain control signals, so there is no back-pressure at the block's edge: a write takes effect on the clock edge where it is presented, and a read is valid combinationally in the same cycle.

Top module: `mio_port`

## Requirements
- R1: After reset the output byte, direction mask, drive-option byte, mode byte and address latch all read as zero, every `pin_oe` bit is 0 and `fast_slew` is 0.
- R2: A read at offset 0 returns `pin_i` combinationally, in the same cycle and with no register stage in between.
- R3: A write at offset 1 (output byte), 2 (direction), 3 (drive options) or 4 (mode) stores `reg_wdata` on that clock edge. A read at the same offset returns the stored byte.
- R4: With a pin's open-drain option off, `pin_oe[i]` is 1 exactly when direction bit i or `pt_oe[i]` is 1.
- R5: Mode byte bits [1:0] pick what every pin drives: 0 selects the output byte, 1 selects `logic_out`, 2 selects the address latch, and 3 selects the output byte.
- R6: For pins 7 to 4, drive-option bit i set to 1 selects open-drain. The pin then drives only a low level (`pin_oe` set and `pin_o` 0 when the selected bit is 0) and releases the line (`pin_oe` 0) when the selected bit is 1.
- R7: Drive-option bits [3:0] appear on `fast_slew[3:0]`. These bits never cause open-drain behaviour on pins 3 to 0.
- R8: In mode 2, while `ale` is 1, the address latch follows `pin_i` three clock edges later, after a two-flop synchronizer and the latch register. It holds its value while `ale` is 0 and in every other mode. `addr_out` shows the latch.
- R9: Writes at offset 0 and at offsets 5 to 7 change no register. Reads at offsets 5 to 7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| pt_oe | input | 8 | Per-pin output enable from external logic |
| logic_out | input | 8 | Combinational logic outputs for mode 1 |
| ale | input | 1 | Address-latch strobe |
| pin_i | input | 8 | Values sampled at the pins |
| pin_o | output | 8 | Values driven toward the pins |
| pin_oe | output | 8 | Per-pin driver enable |
| fast_slew | output | 4 | Fast-edge request for pins 3 to 0 |
| addr_out | output | 8 | Latched address bits |

## Verification
The output path is tried with direction-only enables, external-only enables and mixes of the two. This separates an OR of the two sources from either one alone. The four mode values are each driven with distinct output-byte, logic and latch contents, so a wrong selector shows as a wrong byte. Open-drain is tested with an alternating output byte. This tells a pin that releases on a high level apart from one that keeps driving, and the low nibble under the same option byte shows that slew and open-drain bits are not swapped. The latch is filled with the strobe high, then given new pin values with the strobe low and in another mode; this shows both capture and hold.

// File: rtl/mio_pkg.sv
package mio_pkg;
  typedef enum logic [1:0] {
    SRC_MCU   = 2'd0,
    SRC_LOGIC = 2'd1,
    SRC_ADDR  = 2'd2,
    SRC_ALT   = 2'd3
  } src_mode_e;

  localparam int unsigned REG_AW   = 3;
  localparam logic [REG_AW-1:0] OFS_DIN  = 3'd0;
  localparam logic [REG_AW-1:0] OFS_DOUT = 3'd1;
  localparam logic [REG_AW-1:0] OFS_DIR  = 3'd2;
  localparam logic [REG_AW-1:0] OFS_CFG  = 3'd3;
  localparam logic [REG_AW-1:0] OFS_MODE = 3'd4;
endpackage

// File: rtl/mio_regs.sv
module mio_regs
  import mio_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [W-1:0]      reg_wdata,
  input  logic [W-1:0]      pin_live,
  output logic [W-1:0]      reg_rdata,
  output logic [W-1:0]      dout_q,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      cfg_q,
  output logic [W-1:0]      mode_q
);
  // register bank: async reset to zero, write on the strobe edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      dir_q  <= '0;
      cfg_q  <= '0;
      mode_q <= '0;
    end else if (reg_we) begin
      unique case (reg_addr)
        OFS_DOUT: dout_q <= reg_wdata;
        OFS_DIR:  dir_q  <= reg_wdata;
        OFS_CFG:  cfg_q  <= reg_wdata;
        OFS_MODE: mode_q <= reg_wdata;
        default:  ;
      endcase
    end
  end

  // read mux: offset 0 is the live pin bus with no stage in between
  always_comb begin
    unique case (reg_addr)
      OFS_DIN:  reg_rdata = pin_live;
      OFS_DOUT: reg_rdata = dout_q;
      OFS_DIR:  reg_rdata = dir_q;
      OFS_CFG:  reg_rdata = cfg_q;
      OFS_MODE: reg_rdata = mode_q;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mio_addr_latch.sv
module mio_addr_latch #(
  parameter int unsigned W       = 8,
  parameter int unsigned SYNC_FF = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_async,
  input  logic         strobe,
  input  logic         capture_en,
  output logic [W-1:0] latch_q
);
  logic [W-1:0] stage_q [SYNC_FF];

  generate
    for (genvar s = 0; s < SYNC_FF; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= pin_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  // follows the synchronized pins while the strobe is high, holds otherwise
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   latch_q <= '0;
    else if (strobe && capture_en) latch_q <= stage_q[SYNC_FF-1];
  end
endmodule

// File: rtl/mio_src_sel.sv
module mio_src_sel
  import mio_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  src_mode_e    mode,
  input  logic [W-1:0] dout,
  input  logic [W-1:0] logic_in,
  input  logic [W-1:0] addr_in,
  output logic [W-1:0] src
);
  always_comb begin
    unique case (mode)
      SRC_LOGIC: src = logic_in;
      SRC_ADDR:  src = addr_in;
      default:   src = dout;
    endcase
  end
endmodule

// File: rtl/mio_pin_drive.sv
module mio_pin_drive #(
  parameter int unsigned W        = 8,
  parameter int unsigned OD_FIRST = 4,
  parameter int unsigned FS_CNT   = 4
) (
  input  logic [W-1:0]        src,
  input  logic [W-1:0]        oe_req,
  input  logic [W-1:OD_FIRST] od_en,
  input  logic [FS_CNT-1:0]   slew_en,
  output logic [W-1:0]        pin_o,
  output logic [W-1:0]        pin_oe,
  output logic [FS_CNT-1:0]   fast_slew
);
  generate
    for (genvar i = 0; i < W; i++) begin : g_pin
      if (i >= OD_FIRST) begin : g_od
        // open-drain: pull low only, release instead of driving high
        assign pin_o[i]  = od_en[i] ? 1'b0 : src[i];
        assign pin_oe[i] = oe_req[i] & ~(od_en[i] & src[i]);
      end else begin : g_pp
        assign pin_o[i]  = src[i];
        assign pin_oe[i] = oe_req[i];
      end
    end
    for (genvar j = 0; j < FS_CNT; j++) begin : g_slew
      assign fast_slew[j] = slew_en[j];
    end
  endgenerate
endmodule

// File: rtl/mio_port.sv
module mio_port
  import mio_pkg::*;
#(
  parameter int unsigned W        = 8,
  parameter int unsigned OD_FIRST = 4,
  parameter int unsigned FS_CNT   = 4,
  parameter int unsigned SYNC_FF  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rdata,
  input  logic [W-1:0]      pt_oe,
  input  logic [W-1:0]      logic_out,
  input  logic              ale,
  input  logic [W-1:0]      pin_i,
  output logic [W-1:0]      pin_o,
  output logic [W-1:0]      pin_oe,
  output logic [FS_CNT-1:0] fast_slew,
  output logic [W-1:0]      addr_out
);
  logic [W-1:0] dout_q, dir_q, cfg_q, mode_q;
  logic [W-1:0] src;
  logic [W-1:0] oe_req;
  src_mode_e    mode;
  logic         addr_mode;

  assign mode      = src_mode_e'(mode_q[1:0]);
  assign addr_mode = (mode == SRC_ADDR);
  assign oe_req    = dir_q | pt_oe;

  mio_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .pin_live(pin_i), .reg_rdata(reg_rdata),
    .dout_q(dout_q), .dir_q(dir_q), .cfg_q(cfg_q), .mode_q(mode_q)
  );

  mio_addr_latch #(.W(W), .SYNC_FF(SYNC_FF)) u_alat (
    .clk(clk), .rst_n(rst_n), .pin_async(pin_i), .strobe(ale),
    .capture_en(addr_mode), .latch_q(addr_out)
  );

  mio_src_sel #(.W(W)) u_sel (
    .mode(mode), .dout(dout_q), .logic_in(logic_out),
    .addr_in(addr_out), .src(src)
  );

  mio_pin_drive #(.W(W), .OD_FIRST(OD_FIRST), .FS_CNT(FS_CNT)) u_drv (
    .src(src), .oe_req(oe_req), .od_en(cfg_q[W-1:OD_FIRST]),
    .slew_en(cfg_q[FS_CNT-1:0]), .pin_o(pin_o), .pin_oe(pin_oe),
    .fast_slew(fast_slew)
  );
endmodule

// File: rtl/mio_port_chk.sv
module mio_port_chk #(
  parameter int unsigned W        = 8,
  parameter int unsigned OD_FIRST = 4,
  parameter int unsigned FS_CNT   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        reg_addr,
  input logic              reg_we,
  input logic [W-1:0]      reg_wdata,
  input logic [W-1:0]      reg_rdata,
  input logic [W-1:0]      pt_oe,
  input logic              ale,
  input logic [W-1:0]      pin_i,
  input logic [W-1:0]      pin_o,
  input logic [W-1:0]      pin_oe,
  input logic [FS_CNT-1:0] fast_slew,
  input logic [W-1:0]      addr_out,
  input logic [W-1:0]      dout_q,
  input logic [W-1:0]      dir_q,
  input logic [W-1:0]      cfg_q,
  input logic [W-1:0]      mode_q
);
  localparam logic [W-1:0] OD_MASK = ~((W)'(1) << OD_FIRST) + (W)'(1) == '0 ? '0 :
                                     ({W{1'b1}} << OD_FIRST);

  assert_reset_state_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (pin_oe == '0 && fast_slew == '0 && addr_out == '0));

  assert_live_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 3'd0) |-> (reg_rdata == pin_i));

  assert_dout_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd1) |=> (dout_q == $past(reg_wdata)));

  assert_oe_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe & ~(dir_q | pt_oe)) == '0));

  assert_od_no_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe & pin_o & cfg_q & OD_MASK) == '0));

  assert_slew_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd3) |=> (fast_slew == $past(reg_wdata[FS_CNT-1:0])));

  assert_latch_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale) |=> $stable(addr_out));

  assert_din_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd0) |=> ($stable(dout_q) && $stable(dir_q) &&
                                      $stable(cfg_q) && $stable(mode_q)));
endmodule

bind mio_port mio_port_chk #(.W(W), .OD_FIRST(OD_FIRST), .FS_CNT(FS_CNT)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pt_oe(pt_oe), .ale(ale),
  .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe), .fast_slew(fast_slew),
  .addr_out(addr_out), .dout_q(dout_q), .dir_q(dir_q), .cfg_q(cfg_q),
  .mode_q(mode_q)
);

// File: tb/tb_mio_port.sv
`timescale 1ns/1ps
module tb_mio_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [7:0] pt_oe = '0;
  logic [7:0] logic_out = '0;
  logic       ale = 1'b0;
  logic [7:0] pin_i = '0;
  logic [7:0] pin_o, pin_oe, addr_out;
  logic [3:0] fast_slew;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  mio_port dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pt_oe(pt_oe),
    .logic_out(logic_out), .ale(ale), .pin_i(pin_i), .pin_o(pin_o),
    .pin_oe(pin_oe), .fast_slew(fast_slew), .addr_out(addr_out)
  );

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    for (int a = 1; a <= 4; a++) begin
      rd(3'(a), v);
      chk("R1", "reg after reset", v, 8'h00);
    end
    chk("R1", "pin_oe", pin_oe, 8'h00);
    chk("R1", "fast_slew", {4'h0, fast_slew}, 8'h00);
    chk("R1", "addr_out", addr_out, 8'h00);
  endtask

  task automatic t_live_read;
    @(negedge clk);
    reg_addr = 3'd0; pin_i = 8'hA5;
    #1 chk("R2", "din", reg_rdata, 8'hA5);
    pin_i = 8'h3C;
    #1 chk("R2", "din same cycle", reg_rdata, 8'h3C);
  endtask

  task automatic t_regs;
    logic [7:0] v;
    wr(3'd1, 8'h5A); rd(3'd1, v); chk("R3", "dout", v, 8'h5A);
    wr(3'd2, 8'h81); rd(3'd2, v); chk("R3", "dir", v, 8'h81);
    wr(3'd3, 8'h3C); rd(3'd3, v); chk("R3", "cfg", v, 8'h3C);
    wr(3'd4, 8'hC0); rd(3'd4, v); chk("R3", "mode", v, 8'hC0);
    wr(3'd3, 8'h00); wr(3'd4, 8'h00); wr(3'd2, 8'h00);
  endtask

  task automatic t_oe;
    wr(3'd1, 8'h96);
    wr(3'd2, 8'h0F);
    pt_oe = 8'h00;
    #1 chk("R4", "dir only", pin_oe, 8'h0F);
    pt_oe = 8'h30;
    #1 chk("R4", "dir or pt", pin_oe, 8'h3F);
    wr(3'd2, 8'h00);
    #1 chk("R4", "pt only", pin_oe, 8'h30);
    chk("R5", "mode0 pin_o", pin_o, 8'h96);
    pt_oe = 8'h00;
  endtask

  task automatic t_modes;
    logic_out = 8'h4B;
    wr(3'd4, 8'h01);
    #1 chk("R5", "mode1 logic", pin_o, 8'h4B);
    wr(3'd4, 8'h03);
    #1 chk("R5", "mode3 dout", pin_o, 8'h96);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_open_drain;
    wr(3'd2, 8'hFF);
    wr(3'd1, 8'hA5);
    wr(3'd3, 8'hF0);
    #1 chk("R6", "od pin_oe", pin_oe, 8'h5F);
    chk("R6", "od pin_o", pin_o, 8'h05);
    chk("R7", "no slew from od bits", {4'h0, fast_slew}, 8'h00);
  endtask

  task automatic t_slew;
    wr(3'd1, 8'h00);
    wr(3'd3, 8'h0F);
    #1 chk("R7", "fast_slew", {4'h0, fast_slew}, 8'h0F);
    wr(3'd1, 8'hFF);
    #1 chk("R7", "low nibble stays push-pull", pin_oe, 8'hFF);
    chk("R7", "low nibble drives high", pin_o, 8'hFF);
    wr(3'd3, 8'h00); wr(3'd2, 8'h00);
  endtask

  task automatic t_latch;
    wr(3'd4, 8'h02);
    @(negedge clk);
    pin_i = 8'h9C; ale = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8", "capture", addr_out, 8'h9C);
    ale = 1'b0; pin_i = 8'h11;
    repeat (5) @(negedge clk);
    chk("R8", "hold ale low", addr_out, 8'h9C);
    wr(3'd2, 8'hFF);
    #1 chk("R5", "mode2 latch on pins", pin_o, 8'h9C);
    wr(3'd4, 8'h00);
    @(negedge clk);
    ale = 1'b1; pin_i = 8'h66;
    repeat (5) @(negedge clk);
    chk("R8", "hold other mode", addr_out, 8'h9C);
    ale = 1'b0;
    wr(3'd2, 8'h00);
  endtask

  task automatic t_ignored;
    logic [7:0] v;
    wr(3'd1, 8'h3E); wr(3'd2, 8'h21); wr(3'd3, 8'h42); wr(3'd4, 8'h01);
    wr(3'd0, 8'h77);
    rd(3'd1, v); chk("R9", "dout after off0 write", v, 8'h3E);
    rd(3'd2, v); chk("R9", "dir after off0 write", v, 8'h21);
    rd(3'd3, v); chk("R9", "cfg after off0 write", v, 8'h42);
    rd(3'd4, v); chk("R9", "mode after off0 write", v, 8'h01);
    for (int a = 5; a <= 7; a++) begin
      wr(3'(a), 8'hEE);
      rd(3'(a), v); chk("R9", "unmapped reads zero", v, 8'h00);
    end
    rd(3'd1, v); chk("R9", "dout after unmapped writes", v, 8'h3E);
    rd(3'd3, v); chk("R9", "cfg after unmapped writes", v, 8'h42);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_live_read();
    t_regs();
    t_oe();
    t_modes();
    t_open_drain();
    t_slew();
    t_latch();
    t_ignored();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule